// File: doc/BRIEF.md
# Sticky Fatal Error Code Collector

This block gathers fault indications from the entropy distribution datapath and keeps them in a single 32-bit error-code register. Three command/output FIFOs report their full, empty, write and read status. The collector itself spots the three illegal FIFO events: a write while full, a read while empty, and full and empty at the same time. It records which FIFO failed and also what kind of fault it was. Two state machines and one hardened counter report their own faults as single-cycle pulses. Every recorded bit stays set until reset, and software can only read it.

Software can also force any defined error bit. It writes a 5-bit bit index to a test register. The collector turns that write into a one-cycle internal pulse, and the pulse sets the code bit through the same path a real fault uses. This lets the fatal interrupt and the fatal alert be proven without provoking a real fault. FIFO faults drive the fatal interrupt. State-machine and counter faults drive the fatal alert.

Top module: `fatal_err_collect`

## Requirements
- R1: After reset the error code reads 0, the test register reads 0, and `fatal_intr_o` and `fatal_alert_o` are low.
- R2: When FIFO k (0..2) sees a write while full, bit k and bit 28 of the error code are set at the next clock edge.
- R3: When FIFO k sees a read while empty, bit k and bit 29 are set at the next clock edge.
- R4: When FIFO k reports full and empty in the same cycle, bit k and bit 30 are set at the next clock edge.
- R5: A pulse on the acknowledge-machine, main-machine or counter fault input sets bit 20, 21 or 22 respectively at the next clock edge.
- R6: Set error bits stay set until reset. A register write with select 0, which addresses the code register, changes nothing.
- R7: `fatal_intr_o` is high exactly while any of bits 0..2 or 28..30 is set. `fatal_alert_o` is high exactly while any of bits 20..22 is set.
- R8: A register write with select 1 stores `wdata[4:0]` as a test index. If the index is a defined bit (0,1,2,20,21,22,28,29,30), that code bit becomes set on the second clock edge after the write edge and not before.
- R9: A test index that names an undefined bit sets no error bit.
- R10: `reg_rdata_o` returns the error code while `reg_sel_i` is 0. While it is 1, it returns the stored test index in bits 4:0 with zeros above.
- R11: Error-code bits other than 0..2, 20..22 and 28..30 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_full_i | input | 3 | Per-FIFO full status |
| fifo_empty_i | input | 3 | Per-FIFO empty status |
| fifo_wr_i | input | 3 | Per-FIFO write strobe |
| fifo_rd_i | input | 3 | Per-FIFO read strobe |
| ack_sm_err_i | input | 1 | Acknowledge state machine illegal-state pulse |
| main_sm_err_i | input | 1 | Main state machine illegal-state pulse |
| cntr_err_i | input | 1 | Hardened counter mismatch pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 error code, 1 test index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| fatal_intr_o | output | 1 | Fatal interrupt from FIFO faults |
| fatal_alert_o | output | 1 | Fatal alert from state-machine and counter faults |

## Verification
A corrupted code bit shows on `reg_rdata_o` and on one of the two fatal outputs in the same cycle the bit goes wrong. A lost stickiness bit shows as a fatal output falling, which a correct block never does after reset. A fault in the injection path shows as a bit that appears one edge early, never appears, or appears for an undefined index. The bench reads the code one and two edges after each test write, so all three of these are caught within two cycles.

// File: rtl/fec_pkg.sv
package fec_pkg;
    localparam int CODE_W   = 32;
    localparam int IDX_W    = 5;
    localparam int NUM_FIFO = 3;

    localparam int BIT_ACK_SM   = 20;
    localparam int BIT_MAIN_SM  = 21;
    localparam int BIT_CNTR     = 22;
    localparam int BIT_WR_FULL  = 28;
    localparam int BIT_RD_EMPTY = 29;
    localparam int BIT_BOTH     = 30;

    localparam logic [CODE_W-1:0] INTR_MASK    = 32'h7000_0007;
    localparam logic [CODE_W-1:0] ALERT_MASK   = 32'h0070_0000;
    localparam logic [CODE_W-1:0] DEFINED_MASK = INTR_MASK | ALERT_MASK;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } code_state_t;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [CODE_W-1:0] pulse;
    } inject_state_t;

    function automatic logic idx_defined(input logic [IDX_W-1:0] i);
        return DEFINED_MASK[i];
    endfunction
endpackage

// File: rtl/fifo_fault_classify.sv
module fifo_fault_classify #(
    parameter int NUM_FIFO = fec_pkg::NUM_FIFO
) (
    input  logic [NUM_FIFO-1:0] full_i,
    input  logic [NUM_FIFO-1:0] empty_i,
    input  logic [NUM_FIFO-1:0] wr_i,
    input  logic [NUM_FIFO-1:0] rd_i,
    output logic [NUM_FIFO-1:0] src_o,
    output logic                wr_full_o,
    output logic                rd_empty_o,
    output logic                both_o
);
    logic [NUM_FIFO-1:0] wf, re, fe;

    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_fifo
        assign wf[k]    = wr_i[k] & full_i[k];
        assign re[k]    = rd_i[k] & empty_i[k];
        assign fe[k]    = full_i[k] & empty_i[k];
        assign src_o[k] = wf[k] | re[k] | fe[k];
    end

    assign wr_full_o  = |wf;
    assign rd_empty_o = |re;
    assign both_o     = |fe;
endmodule

// File: rtl/fault_inject.sv
module fault_inject
    import fec_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [CODE_W-1:0] pulse_o
);
    inject_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        if (we_i) begin
            st_d.idx = idx_i;
            if (idx_defined(idx_i)) begin
                st_d.pulse[idx_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o   = st_q.idx;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/fatal_err_collect.sv
module fatal_err_collect
    import fec_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_FIFO-1:0] fifo_full_i,
    input  logic [NUM_FIFO-1:0] fifo_empty_i,
    input  logic [NUM_FIFO-1:0] fifo_wr_i,
    input  logic [NUM_FIFO-1:0] fifo_rd_i,
    input  logic                ack_sm_err_i,
    input  logic                main_sm_err_i,
    input  logic                cntr_err_i,
    input  logic                reg_we_i,
    input  logic                reg_sel_i,
    input  logic [CODE_W-1:0]   reg_wdata_i,
    output logic [CODE_W-1:0]   reg_rdata_o,
    output logic                fatal_intr_o,
    output logic                fatal_alert_o
);
    logic [NUM_FIFO-1:0] fifo_src;
    logic                ev_wr_full, ev_rd_empty, ev_both;
    logic [IDX_W-1:0]    test_idx;
    logic [CODE_W-1:0]   force_vec;
    logic [CODE_W-1:0]   new_err;
    code_state_t         st_d, st_q;

    fifo_fault_classify #(.NUM_FIFO(NUM_FIFO)) u_classify (
        .full_i     (fifo_full_i),
        .empty_i    (fifo_empty_i),
        .wr_i       (fifo_wr_i),
        .rd_i       (fifo_rd_i),
        .src_o      (fifo_src),
        .wr_full_o  (ev_wr_full),
        .rd_empty_o (ev_rd_empty),
        .both_o     (ev_both)
    );

    fault_inject u_inject (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i & reg_sel_i),
        .idx_i   (reg_wdata_i[IDX_W-1:0]),
        .idx_o   (test_idx),
        .pulse_o (force_vec)
    );

    always_comb begin
        new_err                = '0;
        new_err[NUM_FIFO-1:0]  = fifo_src;
        new_err[BIT_WR_FULL]   = ev_wr_full;
        new_err[BIT_RD_EMPTY]  = ev_rd_empty;
        new_err[BIT_BOTH]      = ev_both;
        new_err[BIT_ACK_SM]    = ack_sm_err_i;
        new_err[BIT_MAIN_SM]   = main_sm_err_i;
        new_err[BIT_CNTR]      = cntr_err_i;
        st_d.code = (st_q.code | new_err | force_vec) & DEFINED_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fatal_intr_o  = |(st_q.code & INTR_MASK);
    assign fatal_alert_o = |(st_q.code & ALERT_MASK);
    assign reg_rdata_o   = reg_sel_i ? {{(CODE_W-IDX_W){1'b0}}, test_idx} : st_q.code;
endmodule

// File: rtl/fatal_err_collect_chk.sv
module fatal_err_collect_chk
    import fec_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic [NUM_FIFO-1:0] fifo_full_i,
    input logic [NUM_FIFO-1:0] fifo_empty_i,
    input logic [NUM_FIFO-1:0] fifo_wr_i,
    input logic [NUM_FIFO-1:0] fifo_rd_i,
    input logic                ack_sm_err_i,
    input logic                main_sm_err_i,
    input logic                cntr_err_i,
    input logic                reg_we_i,
    input logic                reg_sel_i,
    input logic [CODE_W-1:0]   reg_wdata_i,
    input logic [CODE_W-1:0]   code_q,
    input logic [CODE_W-1:0]   force_vec,
    input logic                fatal_intr_o,
    input logic                fatal_alert_o
);
    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_fifo_chk
        assert_wr_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fifo_wr_i[k] && fifo_full_i[k]) |=> (code_q[k] && code_q[BIT_WR_FULL]));
        assert_rd_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fifo_rd_i[k] && fifo_empty_i[k]) |=> (code_q[k] && code_q[BIT_RD_EMPTY]));
        assert_both_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fifo_full_i[k] && fifo_empty_i[k]) |=> (code_q[k] && code_q[BIT_BOTH]));
    end

    assert_ack_sm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_sm_err_i |=> code_q[BIT_ACK_SM]);
    assert_cntr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cntr_err_i |=> code_q[BIT_CNTR]);

    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(code_q) & ~code_q) == '0));

    assert_alert_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fatal_alert_o) |-> $past(ack_sm_err_i || main_sm_err_i || cntr_err_i
                                       || (|(force_vec & ALERT_MASK))));
    assert_intr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fatal_intr_o |=> fatal_intr_o);

    assert_inject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_sel_i && idx_defined(reg_wdata_i[IDX_W-1:0]))
            |=> ##1 code_q[$past(reg_wdata_i[IDX_W-1:0], 2)]);

    assert_bad_idx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_sel_i && !idx_defined(reg_wdata_i[IDX_W-1:0]))
            |=> (force_vec == '0));

    assert_undef_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((code_q & ~DEFINED_MASK) == '0));
endmodule

bind fatal_err_collect fatal_err_collect_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fifo_full_i   (fifo_full_i),
    .fifo_empty_i  (fifo_empty_i),
    .fifo_wr_i     (fifo_wr_i),
    .fifo_rd_i     (fifo_rd_i),
    .ack_sm_err_i  (ack_sm_err_i),
    .main_sm_err_i (main_sm_err_i),
    .cntr_err_i    (cntr_err_i),
    .reg_we_i      (reg_we_i),
    .reg_sel_i     (reg_sel_i),
    .reg_wdata_i   (reg_wdata_i),
    .code_q        (st_q.code),
    .force_vec     (force_vec),
    .fatal_intr_o  (fatal_intr_o),
    .fatal_alert_o (fatal_alert_o)
);

// File: tb/fatal_err_collect_tb.sv
module fatal_err_collect_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  fifo_full_i = '0, fifo_empty_i = '0, fifo_wr_i = '0, fifo_rd_i = '0;
    logic        ack_sm_err_i = 1'b0, main_sm_err_i = 1'b0, cntr_err_i = 1'b0;
    logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        fatal_intr_o, fatal_alert_o;

    int checks = 0;
    int failures = 0;

    always #5 clk_i = ~clk_i;

    fatal_err_collect u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        fifo_full_i = '0; fifo_empty_i = '0; fifo_wr_i = '0; fifo_rd_i = '0;
        ack_sm_err_i = 0; main_sm_err_i = 0; cntr_err_i = 0;
        reg_we_i = 0; reg_sel_i = 0; reg_wdata_i = '0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    function automatic logic [31:0] code_of(input int a, input int b);
        logic [31:0] v = '0;
        v[a] = 1'b1;
        v[b] = 1'b1;
        return v;
    endfunction

    task automatic read_code(output logic [31:0] v);
        reg_sel_i = 1'b0;
        #1 v = reg_rdata_o;
    endtask

    task automatic t_reset_R1();
        logic [31:0] v;
        do_reset();
        read_code(v);
        chk("R1 code", v, 32'h0);
        reg_sel_i = 1'b1;
        #1 chk("R1 test idx", reg_rdata_o, 32'h0);
        reg_sel_i = 1'b0;
        chk("R1 outputs", {30'b0, fatal_intr_o, fatal_alert_o}, 32'h0);
    endtask

    task automatic t_wr_full_R2();
        logic [31:0] v;
        do_reset();
        fifo_full_i = 3'b010; fifo_wr_i = 3'b010;
        @(negedge clk_i);
        fifo_full_i = '0; fifo_wr_i = '0;
        read_code(v);
        chk("R2 write-full fifo1", v, code_of(1, 28));
        chk("R7 intr after fifo fault", {31'b0, fatal_intr_o}, 32'h1);
        chk("R7 alert stays low", {31'b0, fatal_alert_o}, 32'h0);
    endtask

    task automatic t_rd_empty_R3();
        logic [31:0] v;
        do_reset();
        fifo_empty_i = 3'b100; fifo_rd_i = 3'b100;
        @(negedge clk_i);
        fifo_empty_i = '0; fifo_rd_i = '0;
        read_code(v);
        chk("R3 read-empty fifo2", v, code_of(2, 29));
        // a plain write to a non-full FIFO is no fault
        fifo_wr_i = 3'b001;
        @(negedge clk_i);
        fifo_wr_i = '0;
        read_code(v);
        chk("R3 normal write no fault", v, code_of(2, 29));
    endtask

    task automatic t_both_R4();
        logic [31:0] v;
        do_reset();
        fifo_full_i = 3'b001; fifo_empty_i = 3'b001;
        @(negedge clk_i);
        fifo_full_i = '0; fifo_empty_i = '0;
        read_code(v);
        chk("R4 full+empty fifo0", v, code_of(0, 30));
    endtask

    task automatic t_sm_R5_R7();
        logic [31:0] v;
        do_reset();
        main_sm_err_i = 1'b1;
        @(negedge clk_i);
        main_sm_err_i = 1'b0;
        read_code(v);
        chk("R5 main sm bit21", v, 32'h0020_0000);
        chk("R7 alert", {31'b0, fatal_alert_o}, 32'h1);
        chk("R7 intr low", {31'b0, fatal_intr_o}, 32'h0);
        ack_sm_err_i = 1'b1; cntr_err_i = 1'b1;
        @(negedge clk_i);
        ack_sm_err_i = 1'b0; cntr_err_i = 1'b0;
        read_code(v);
        chk("R5 ack+cntr bits", v, 32'h0070_0000);
    endtask

    task automatic t_sticky_R6();
        logic [31:0] v;
        do_reset();
        cntr_err_i = 1'b1;
        @(negedge clk_i);
        cntr_err_i = 1'b0;
        reg_we_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 32'h0;
        @(negedge clk_i);
        reg_we_i = 1'b0;
        repeat (3) @(negedge clk_i);
        read_code(v);
        chk("R6 sticky after write", v, 32'h0040_0000);
        chk("R6 alert held", {31'b0, fatal_alert_o}, 32'h1);
    endtask

    task automatic t_inject_R8();
        logic [31:0] v;
        do_reset();
        reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 32'd21;
        @(negedge clk_i);
        reg_we_i = 1'b0;
        read_code(v);
        chk("R8 not yet after one edge", v, 32'h0);
        @(negedge clk_i);
        read_code(v);
        chk("R8 bit21 after two edges", v, 32'h0020_0000);
        chk("R8 alert via inject", {31'b0, fatal_alert_o}, 32'h1);
        reg_sel_i = 1'b1;
        #1 chk("R10 test idx readback", reg_rdata_o, 32'd21);
        reg_we_i = 1'b1; reg_wdata_i = 32'd29;
        @(negedge clk_i);
        reg_we_i = 1'b0;
        @(negedge clk_i);
        read_code(v);
        chk("R8 bit29 injected", v, 32'h2020_0000);
        chk("R7 intr via inject", {31'b0, fatal_intr_o}, 32'h1);
    endtask

    task automatic t_bad_idx_R9();
        logic [31:0] v;
        do_reset();
        reg_we_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 32'hFFFF_FFE5;
        @(negedge clk_i);
        reg_wdata_i = 32'd31;
        @(negedge clk_i);
        reg_we_i = 1'b0;
        repeat (3) @(negedge clk_i);
        read_code(v);
        chk("R9 undefined idx ignored", v, 32'h0);
        chk("R9 outputs low", {30'b0, fatal_intr_o, fatal_alert_o}, 32'h0);
        reg_sel_i = 1'b1;
        #1 chk("R10 idx upper bits zero", reg_rdata_o, 32'd31);
        reg_sel_i = 1'b0;
    endtask

    task automatic t_all_R11();
        logic [31:0] v;
        do_reset();
        fifo_full_i = 3'b111; fifo_empty_i = 3'b111; fifo_wr_i = 3'b111; fifo_rd_i = 3'b111;
        ack_sm_err_i = 1; main_sm_err_i = 1; cntr_err_i = 1;
        @(negedge clk_i);
        fifo_full_i = '0; fifo_empty_i = '0; fifo_wr_i = '0; fifo_rd_i = '0;
        ack_sm_err_i = 0; main_sm_err_i = 0; cntr_err_i = 0;
        read_code(v);
        chk("R11 only defined bits", v, 32'h7070_0007);
    endtask

    initial begin
        fork
            begin
                t_reset_R1();
                t_wr_full_R2();
                t_rd_empty_R3();
                t_both_R4();
                t_sm_R5_R7();
                t_sticky_R6();
                t_inject_R8();
                t_bad_idx_R9();
                t_all_R11();
            end
            begin
                repeat (20000) @(posedge clk_i);
                checks++;
                failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule